// File: doc/BRIEF.md
# Infrared Break-Beam Touch Locator

This block turns an infrared break-beam grid, placed in front of a bar-graph display, into a touch position. One output drives every emitter at once with a square-wave carrier near 38 kHz, divided down from a 50 MHz system clock. Each receiver pulls its line low while it sees the modulated light. The line goes high when a finger blocks that beam.

There are five vertical beams, one per frequency band, and seven horizontal beams that mark height. Every receiver line passes through a two-flop synchroniser and a per-beam hold filter, so short glitches are dropped. The locator then looks for exactly one blocked vertical beam. When it finds one, it reports that band together with a level taken from the highest blocked horizontal beam. Each touch produces one valid strobe. A new strobe can only follow after the whole grid has cleared.

Top module: `ir_touch_locator`

## Requirements
- R1: `carrier_o` toggles every `CARRIER_HALF` clocks (658 by default, about 37.99 kHz at 50 MHz), giving 50% duty. The first toggle comes `CARRIER_HALF` clocks after reset is released.
- R2: While `rst_ni` is low, `carrier_o` is 0 and `touch_valid_o` is 0. Both `band_o` and `level_o` are 0, and every beam is treated as clear.
- R3: A receiver bit at 1 means its beam is blocked, and 0 means light is received. Bit i of `col_rx_i` is band i. Bit 0 of `row_rx_i` is the lowest row.
- R4: A beam counts as blocked only after its synchronised input has been 1 for `HOLD_CYCLES` consecutive clocks. A shorter pulse has no effect.
- R5: A blocked beam counts as clear again only after `HOLD_CYCLES` consecutive clocks at 0. A shorter gap in a held touch does not end that touch.
- R6: The block raises `touch_valid_o` for exactly one clock when the locator is armed, exactly one column is blocked and at least one row is blocked. In that clock `band_o` gives the column index (0 to 4).
- R7: `level_o` in the strobe clock is the index of the highest blocked row plus one (1 to 7).
- R8: When two or more columns are blocked, no strobe is issued.
- R9: After a strobe, no further strobe is issued until every column and every row has been seen as clear. A changed row pattern while the column stays blocked does not count as a clear.
- R10: `band_o` and `level_o` keep their last reported values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| col_rx_i | input | 5 | Column receiver lines, 1 = beam blocked |
| row_rx_i | input | 7 | Row receiver lines, 1 = beam blocked, bit 0 lowest |
| carrier_o | output | 1 | Emitter carrier square wave |
| touch_valid_o | output | 1 | One-clock strobe for a new touch |
| band_o | output | 3 | Selected band index |
| level_o | output | 3 | Requested level, 1 to 7 |

## Verification
The assertions assume that reset is applied from time zero and that the carrier divider is never stalled. They check the carrier period against a counter kept in the checker. For the touch outputs, they only rely on the strobe being a single clock and on the reported band and level staying in range.

The bench changes the receiver lines only on falling clock edges. Every pattern it applies is held either clearly shorter or clearly longer than the hold time, so each case, glitch or touch, has a single expected outcome. Multi-column cases change all blocked columns in the same clock, so no single-column window can open between them.

// File: rtl/ir_touch_pkg.sv
package ir_touch_pkg;
  typedef enum logic {
    ARMED  = 1'b0,
    LOCKED = 1'b1
  } lock_state_e;
endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int unsigned HALF = 658
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic carrier_o
);
  localparam int unsigned CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             car_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      car_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier_o = car_q;
endmodule

// File: rtl/ir_beam_filter.sv
module ir_beam_filter #(
  parameter int unsigned HOLD = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic blocked_o
);
  localparam int unsigned CNT_W = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] run_q;
  logic             state_q;
  logic             differ;

  assign differ = sync_q[1] ^ state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      run_q   <= '0;
      state_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (!differ) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        run_q   <= '0;
        state_q <= sync_q[1];
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign blocked_o = state_q;
endmodule

// File: rtl/ir_touch_decode.sv
module ir_touch_decode
  import ir_touch_pkg::*;
#(
  parameter int unsigned N_COL  = 5,
  parameter int unsigned N_ROW  = 7,
  parameter int unsigned BAND_W = 3,
  parameter int unsigned LVL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_COL-1:0]  col_blk_i,
  input  logic [N_ROW-1:0]  row_blk_i,
  output logic              valid_o,
  output logic [BAND_W-1:0] band_o,
  output logic [LVL_W-1:0]  level_o
);
  lock_state_e       state_q;
  logic              valid_q;
  logic [BAND_W-1:0] band_q;
  logic [LVL_W-1:0]  lvl_q;

  logic              one_col;
  logic              any_row;
  logic              all_clear;
  logic              fire;
  logic [BAND_W-1:0] band_c;
  logic [LVL_W-1:0]  lvl_c;

  always_comb begin
    band_c = '0;
    for (int i = 0; i < int'(N_COL); i++) begin
      if (col_blk_i[i]) band_c = BAND_W'(i);
    end
  end

  // highest blocked row wins: ascending scan, last hit kept
  always_comb begin
    lvl_c = '0;
    for (int i = 0; i < int'(N_ROW); i++) begin
      if (row_blk_i[i]) lvl_c = LVL_W'(i + 1);
    end
  end

  assign one_col   = $onehot(col_blk_i);
  assign any_row   = |row_blk_i;
  assign all_clear = ~|{col_blk_i, row_blk_i};
  assign fire      = (state_q == ARMED) && one_col && any_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARMED;
      valid_q <= 1'b0;
      band_q  <= '0;
      lvl_q   <= '0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        state_q <= LOCKED;
        band_q  <= band_c;
        lvl_q   <= lvl_c;
      end else if (all_clear) begin
        state_q <= ARMED;
      end
    end
  end

  assign valid_o = valid_q;
  assign band_o  = band_q;
  assign level_o = lvl_q;
endmodule

// File: rtl/ir_touch_locator.sv
module ir_touch_locator #(
  parameter int unsigned N_COL        = 5,
  parameter int unsigned N_ROW        = 7,
  parameter int unsigned CARRIER_HALF = 658,
  parameter int unsigned HOLD_CYCLES  = 500000,
  localparam int unsigned BAND_W      = (N_COL > 2) ? $clog2(N_COL) : 1,
  localparam int unsigned LVL_W       = $clog2(N_ROW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_COL-1:0]  col_rx_i,
  input  logic [N_ROW-1:0]  row_rx_i,
  output logic              carrier_o,
  output logic              touch_valid_o,
  output logic [BAND_W-1:0] band_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [N_COL-1:0] col_blk;
  logic [N_ROW-1:0] row_blk;

  ir_carrier_gen #(.HALF(CARRIER_HALF)) u_carrier (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .carrier_o (carrier_o)
  );

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    ir_beam_filter #(.HOLD(HOLD_CYCLES)) u_flt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raw_i     (col_rx_i[c]),
      .blocked_o (col_blk[c])
    );
  end

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    ir_beam_filter #(.HOLD(HOLD_CYCLES)) u_flt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raw_i     (row_rx_i[r]),
      .blocked_o (row_blk[r])
    );
  end

  ir_touch_decode #(
    .N_COL  (N_COL),
    .N_ROW  (N_ROW),
    .BAND_W (BAND_W),
    .LVL_W  (LVL_W)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .col_blk_i (col_blk),
    .row_blk_i (row_blk),
    .valid_o   (touch_valid_o),
    .band_o    (band_o),
    .level_o   (level_o)
  );
endmodule

// File: rtl/ir_touch_locator_chk.sv
module ir_touch_locator_chk #(
  parameter int unsigned N_COL        = 5,
  parameter int unsigned N_ROW        = 7,
  parameter int unsigned CARRIER_HALF = 658,
  parameter int unsigned BAND_W       = 3,
  parameter int unsigned LVL_W        = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              carrier_o,
  input logic              touch_valid_o,
  input logic [BAND_W-1:0] band_o,
  input logic [LVL_W-1:0]  level_o
);
  logic        prev_q;
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= carrier_o;
      run_q  <= (carrier_o != prev_q) ? 32'd1 : run_q + 32'd1;
    end
  end

  a_r1_toggle_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carrier_o != prev_q) |-> (run_q == 32'(CARRIER_HALF)));

  a_r1_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == 32'(CARRIER_HALF)) |-> (carrier_o != prev_q));

  a_r2_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!carrier_o && !touch_valid_o));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_valid_o |=> !touch_valid_o);

  a_r6_band_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_valid_o |-> (band_o < BAND_W'(N_COL)));

  a_r7_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_valid_o |-> ((level_o != '0) && (32'(level_o) <= 32'(N_ROW))));

  a_r10_hold_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(band_o) |-> touch_valid_o);

  a_r10_hold_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o) |-> touch_valid_o);
endmodule

bind ir_touch_locator ir_touch_locator_chk #(
  .N_COL        (N_COL),
  .N_ROW        (N_ROW),
  .CARRIER_HALF (CARRIER_HALF),
  .BAND_W       (BAND_W),
  .LVL_W        (LVL_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .carrier_o     (carrier_o),
  .touch_valid_o (touch_valid_o),
  .band_o        (band_o),
  .level_o       (level_o)
);

// File: tb/tb_ir_touch_locator.sv
module tb_ir_touch_locator;
  localparam int HALF = 5;
  localparam int HOLD = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [4:0] col_rx_i;
  logic [6:0] row_rx_i;
  logic       carrier_o;
  logic       touch_valid_o;
  logic [2:0] band_o;
  logic [2:0] level_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [11:0] pipe[$];
  int          run_m[12];
  bit          blk_m[12];
  int          ccnt_m = 0;
  bit          car_m = 0;
  bit          armed_m = 1;
  bit          strobe_m = 0;
  int          band_m = 0;
  int          lvl_m = 0;

  int          seen = 0;
  int          seen_band = 0;
  int          seen_lvl = 0;

  ir_touch_locator #(
    .CARRIER_HALF (HALF),
    .HOLD_CYCLES  (HOLD)
  ) dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .col_rx_i      (col_rx_i),
    .row_rx_i      (row_rx_i),
    .carrier_o     (carrier_o),
    .touch_valid_o (touch_valid_o),
    .band_o        (band_o),
    .level_o       (level_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int ncol;
    int hi;
    logic [11:0] d;
    ccnt_m++;
    if (ccnt_m == HALF) begin
      car_m  = !car_m;
      ccnt_m = 0;
    end
    ncol = 0; hi = 0;
    for (int i = 0; i < 5; i++) if (blk_m[i]) ncol++;
    for (int i = 0; i < 7; i++) if (blk_m[5+i]) hi = i + 1;
    strobe_m = armed_m && (ncol == 1) && (hi != 0);
    if (strobe_m) begin
      armed_m = 0;
      lvl_m   = hi;
      for (int i = 0; i < 5; i++) if (blk_m[i]) band_m = i;
    end else if (ncol == 0 && hi == 0) begin
      armed_m = 1;
    end
    d = pipe.pop_front();
    pipe.push_back({row_rx_i, col_rx_i});
    for (int b = 0; b < 12; b++) begin
      if (d[b] != blk_m[b]) begin
        run_m[b]++;
        if (run_m[b] == HOLD) begin
          blk_m[b] = d[b];
          run_m[b] = 0;
        end
      end else begin
        run_m[b] = 0;
      end
    end
  endtask

  initial begin
    pipe.push_back('0);
    pipe.push_back('0);
    for (int b = 0; b < 12; b++) begin run_m[b] = 0; blk_m[b] = 0; end
    forever begin
      @(posedge clk_i);
      if (rst_ni === 1'b1) model_step();
      #1;
      if (rst_ni === 1'b1) begin
        check("R1 carrier", int'(carrier_o), int'(car_m));
        check("R6 strobe", int'(touch_valid_o), int'(strobe_m));
        check("R10 band", int'(band_o), band_m);
        check("R10 level", int'(level_o), lvl_m);
        if (touch_valid_o) begin
          seen++; seen_band = band_o; seen_lvl = level_o;
        end
      end
    end
  end

  task automatic drive(input logic [4:0] c, input logic [6:0] r, input int cycles);
    @(negedge clk_i);
    col_rx_i = c;
    row_rx_i = r;
    repeat (cycles - 1) @(negedge clk_i);
  endtask

  initial begin
    rst_ni   = 1'b0;
    col_rx_i = '0;
    row_rx_i = '0;
    repeat (3) @(negedge clk_i);
    check("R2 carrier in reset", int'(carrier_o), 0);
    check("R2 strobe in reset", int'(touch_valid_o), 0);
    check("R2 band in reset", int'(band_o), 0);
    check("R2 level in reset", int'(level_o), 0);
    rst_ni = 1'b1;
    drive('0, '0, 20);

    // R4: short pulses below hold time are dropped
    seen = 0;
    drive(5'b00010, 7'b0000100, 4);
    drive('0, '0, 30);
    check("R4 glitch no strobe", seen, 0);

    // R3 R6 R7: col 2, rows 0..3 -> band 2 level 4
    seen = 0;
    drive(5'b00100, 7'b0001111, 30);
    check("R6 one strobe", seen, 1);
    check("R6 band", seen_band, 2);
    check("R7 level", seen_lvl, 4);
    // R9: rows drop and return while column held
    drive(5'b00100, 7'b0000000, 20);
    drive(5'b00100, 7'b0110000, 30);
    check("R9 no repeat while column held", seen, 1);
    check("R10 level held", int'(level_o), 4);
    drive('0, '0, 30);

    // R8: two columns -> nothing
    seen = 0;
    drive(5'b01100, 7'b0000011, 30);
    check("R8 multi column", seen, 0);
    drive('0, '0, 30);

    // R7: top row, last band
    seen = 0;
    drive(5'b10000, 7'b1000000, 30);
    check("R6 band top", seen_band, 4);
    check("R7 level top", seen_lvl, 7);
    drive('0, '0, 30);

    // R3 R7: bottom row, first band
    seen = 0;
    drive(5'b00001, 7'b0000001, 30);
    check("R3 band zero", seen_band, 0);
    check("R7 level one", seen_lvl, 1);
    drive('0, '0, 30);

    // R5: brief full clear inside a touch does not re-arm
    seen = 0;
    drive(5'b01000, 7'b0100000, 30);
    drive('0, '0, 3);
    drive(5'b01000, 7'b0100000, 30);
    check("R5 short clear no re-arm", seen, 1);
    check("R7 level six", seen_lvl, 6);
    drive('0, '0, 30);

    // R9: re-arm after full clear
    seen = 0;
    drive(5'b01000, 7'b0000010, 30);
    check("R9 re-armed", seen, 1);
    check("R7 level two", seen_lvl, 2);
    drive('0, '0, 20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule